// File: doc/BRIEF.md
# Direct-Mapped Write-Back Block Cache

This block sits between a load/store unit and a word-wide memory port. It keeps a small number of lines, each holding a block of several words together with a tag, a valid flag and a modified flag. A CPU access is looked up in the line picked by the index bits of its byte address. A hit is answered in the same cycle: the word is returned for a read, or the line is updated for a write. A miss raises a stall, and the cache brings in the whole block that holds the requested word before it serves the access.

Writes stay in the cache. They mark the line as modified and do not go to memory. When a miss needs a line whose contents were modified, the old block is first streamed out to memory. Only then is the new block streamed in. A line that was never written is dropped without any memory traffic. Write misses allocate: the block is fetched first and the written word is merged into it afterwards. Memory transfers run one word per beat under a request/acknowledge handshake.

The CPU holds its request fields steady for as long as the stall is high. The parameters must give a power-of-two line count and a block of at least two words.

Top module: `dcache_wb`

## Requirements
- R1: With default parameters, the 10-bit byte address splits into tag = addr[9:7], index = addr[6:4], word-in-block = addr[3:2]. The two lowest address bits do not affect which word is selected.
- R2: A read that hits (the line is valid and its stored tag equals the address tag) gives the word on cpu_rdata with cpu_stall low in the same cycle, and causes no memory traffic.
- R3: After reset no line is valid. Any miss holds cpu_stall high until the requested word can be delivered. cpu_stall is never high while cpu_req is low.
- R4: A miss reads the whole block from memory in exactly BLK_WORDS read beats. The beats go in ascending word order, and mem_addr carries the byte address of each word, starting at the block base.
- R5: A write that hits updates only the cached word and marks the line modified. Memory is not written, and a later read of that word returns the new value.
- R6: A miss to a line marked modified first writes the old block back: BLK_WORDS write beats at the old tag's block address, carrying the cached words. All of these complete before the first read beat of the refill.
- R7: A miss to a line that is valid but unmodified, or not valid, produces no write beats. A freshly refilled line counts as unmodified.
- R8: A write miss refills the block, then merges the written word and marks the line modified. The other words of the block keep their memory values.
- R9: A memory request stays asserted, with mem_addr and mem_we stable, until mem_ack. Each acknowledged beat moves exactly one word.
- R10: Reset clears every valid and modified flag. A line that was modified before reset is never written back, and its block is fetched again from memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access valid, held while stalled |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_wdata | input | DATA_W | Write word |
| cpu_rdata | output | DATA_W | Read word, valid when cpu_req and not cpu_stall |
| cpu_stall | output | 1 | Access not yet served |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | 1 = write-back beat, 0 = refill beat |
| mem_addr | output | ADDR_W | Byte address of the beat's word |
| mem_wdata | output | DATA_W | Word written on a write-back beat |
| mem_rdata | input | DATA_W | Word returned on a refill beat |
| mem_ack | input | 1 | Beat completes on this edge |

## Verification
The bench runs a single fixed access sequence. It includes reads that hit in a just-filled line, so a correct block refill is told apart from a single-word fetch. It includes write hits followed by eviction of the same line, which shows whether data written to the cache actually reaches memory on write-back. Evictions of a clean line and of a dirty line are both exercised, which separates a conditional write-back from one that always or never happens. A write miss shows that allocation merges the word after the refill. A reset that lands on a dirty line shows whether the modified flag is really cleared. Beat counts, beat addresses and the order of write and read beats are logged by the memory model, so the ordering on eviction is observed at the port.

// File: rtl/dcache_wb.sv
module dcache_wb #(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int LINES     = 8,
  parameter int BLK_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  localparam int BYTE_W = $clog2(DATA_W/8);
  localparam int WSEL_W = $clog2(BLK_WORDS);
  localparam int OFF_W  = BYTE_W + WSEL_W;
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

  typedef enum logic [1:0] {S_IDLE, S_EVICT, S_REFILL} state_t;

  state_t              state_q;
  logic [LINES-1:0]    valid_q, dirty_q;
  logic [TAG_W-1:0]    tag_q  [LINES];
  logic [DATA_W-1:0]   data_q [LINES][BLK_WORDS];
  logic [TAG_W-1:0]    miss_tag_q;
  logic [IDX_W-1:0]    miss_idx_q;
  logic [WSEL_W-1:0]   beat_q;

  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WSEL_W-1:0] req_word;
  logic              hit, last_beat, wr_hit;

  assign req_tag   = cpu_addr[ADDR_W-1 -: TAG_W];
  assign req_idx   = cpu_addr[OFF_W +: IDX_W];
  assign req_word  = cpu_addr[BYTE_W +: WSEL_W];
  assign hit       = valid_q[req_idx] && (tag_q[req_idx] == req_tag);
  assign last_beat = (beat_q == WSEL_W'(BLK_WORDS-1));
  assign wr_hit    = (state_q == S_IDLE) && cpu_req && cpu_we && hit;

  assign cpu_rdata = data_q[req_idx][req_word];
  assign cpu_stall = cpu_req && ((state_q != S_IDLE) || !hit);

  assign mem_req   = (state_q != S_IDLE);
  assign mem_we    = (state_q == S_EVICT);
  assign mem_wdata = data_q[miss_idx_q][beat_q];
  assign mem_addr  = {(state_q == S_EVICT) ? tag_q[miss_idx_q] : miss_tag_q,
                      miss_idx_q, beat_q, {BYTE_W{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      valid_q    <= '0;
      dirty_q    <= '0;
      miss_tag_q <= '0;
      miss_idx_q <= '0;
      beat_q     <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (wr_hit) dirty_q[req_idx] <= 1'b1;
          if (cpu_req && !hit) begin
            miss_tag_q <= req_tag;
            miss_idx_q <= req_idx;
            beat_q     <= '0;
            state_q    <= (valid_q[req_idx] && dirty_q[req_idx]) ? S_EVICT : S_REFILL;
          end
        end
        S_EVICT: if (mem_ack) begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) begin
            dirty_q[miss_idx_q] <= 1'b0;
            valid_q[miss_idx_q] <= 1'b0;
            state_q             <= S_REFILL;
          end
        end
        S_REFILL: if (mem_ack) begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) begin
            valid_q[miss_idx_q] <= 1'b1;
            dirty_q[miss_idx_q] <= 1'b0;
            state_q             <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_hit) data_q[req_idx][req_word] <= cpu_wdata;
    if (state_q == S_REFILL && mem_ack) begin
      data_q[miss_idx_q][beat_q] <= mem_rdata;
      if (last_beat) tag_q[miss_idx_q] <= miss_tag_q;
    end
  end
endmodule

module dcache_wb_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_stall,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack
);
  a_r2_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_stall) |-> !mem_req);
  a_r3_stall_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> cpu_req);
  a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  a_r6_no_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> !mem_we);
  a_r6_write_has_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);
endmodule

bind dcache_wb dcache_wb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_stall(cpu_stall),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/test_dcache_wb.sv
module test_dcache_wb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  // fields: we, addr, wdata, expected rdata, write beats, read beats, write-back base
  localparam logic [90:0] VEC [NV] = '{
    {1'b0, 10'h010, 32'h0,        32'h10000004, 3'd0, 3'd4, 10'h000},
    {1'b0, 10'h01C, 32'h0,        32'h10000007, 3'd0, 3'd0, 10'h000},
    {1'b1, 10'h014, 32'hDEADBEEF, 32'h0,        3'd0, 3'd0, 10'h000},
    {1'b0, 10'h014, 32'h0,        32'hDEADBEEF, 3'd0, 3'd0, 10'h000},
    {1'b0, 10'h090, 32'h0,        32'h10000024, 3'd4, 3'd4, 10'h010},
    {1'b0, 10'h014, 32'h0,        32'hDEADBEEF, 3'd0, 3'd4, 10'h000},
    {1'b1, 10'h238, 32'h12345678, 32'h0,        3'd0, 3'd4, 10'h000},
    {1'b0, 10'h234, 32'h0,        32'h1000008D, 3'd0, 3'd0, 10'h000},
    {1'b0, 10'h238, 32'h0,        32'h12345678, 3'd0, 3'd0, 10'h000},
    {1'b0, 10'h0B0, 32'h0,        32'h1000002C, 3'd4, 3'd4, 10'h230},
    {1'b0, 10'h238, 32'h0,        32'h12345678, 3'd0, 3'd4, 10'h000},
    {1'b0, 10'h23B, 32'h0,        32'h12345678, 3'd0, 3'd0, 10'h000}
  };

  logic        clk = 0, rst_n = 0;
  logic        cpu_req = 0, cpu_we = 0;
  logic [9:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  logic        cpu_stall, mem_req, mem_we;
  logic [9:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 0;

  int checks = 0, fails = 0;
  int wr_n, rd_n, seq, last_wr_seq, first_rd_seq, stall_cycles;
  logic [9:0]  wr_log [8];
  logic [9:0]  rd_log [8];
  logic [31:0] mem [256];
  logic [31:0] got;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcache_wb i_dcache_wb (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack)
  );

  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack   = 1'b1;
      mem_rdata = mem[mem_addr[9:2]];
      if (mem_we) begin
        mem[mem_addr[9:2]] = mem_wdata;
        if (wr_n < 8) wr_log[wr_n] = mem_addr;
        wr_n++;
        last_wr_seq = seq;
      end else begin
        if (rd_n < 8) rd_log[rd_n] = mem_addr;
        if (rd_n == 0) first_rd_seq = seq;
        rd_n++;
      end
      seq++;
    end else begin
      mem_ack = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic access(input logic we, input logic [9:0] a, input logic [31:0] d);
    wr_n = 0; rd_n = 0; seq = 0; last_wr_seq = -1; first_rd_seq = -1; stall_cycles = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    #1;
    while (cpu_stall) begin
      stall_cycles++;
      if (stall_cycles > 1000) begin
        chk("R3 stall timeout", 32'd1, 32'd0);
        finish_run();
      end
      @(negedge clk);
      #1;
    end
    got = cpu_rdata;
    @(posedge clk);
    @(negedge clk);
    cpu_req = 0; cpu_we = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h10000000 | i;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 reset stall", {31'b0, cpu_stall}, 32'd0);
    chk("R10 reset mem_req", {31'b0, mem_req}, 32'd0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      logic        v_we;
      logic [9:0]  v_a, v_wb;
      logic [31:0] v_d, v_e;
      logic [2:0]  v_wr, v_rd;
      {v_we, v_a, v_d, v_e, v_wr, v_rd, v_wb} = VEC[i];
      access(v_we, v_a, v_d);
      if (!v_we) chk(v_rd != 0 ? "R4 refill data" : "R2 hit data", got, v_e);
      chk(v_wr != 0 ? "R6 write-back beats" : "R7 no write-back", wr_n, {29'b0, v_wr});
      chk("R4 read beats", rd_n, {29'b0, v_rd});
      chk("R3 stall on miss", {31'b0, stall_cycles > 0}, {31'b0, v_rd != 0});
      if (v_rd != 0)
        for (int k = 0; k < 4; k++)
          chk("R9 refill address", {22'b0, rd_log[k]}, {22'b0, (v_a & 10'h3F0) + 10'(4*k)});
      if (v_wr != 0) begin
        for (int k = 0; k < 4; k++)
          chk("R6 write-back address", {22'b0, wr_log[k]}, {22'b0, v_wb + 10'(4*k)});
        chk("R6 write-back before refill", {31'b0, last_wr_seq < first_rd_seq}, 32'd1);
      end
      if (i == 2) chk("R5 memory untouched on write hit", mem[5], 32'h10000005);
      if (i == 6) chk("R8 memory untouched on write miss", mem[8'h8E], 32'h1000008E);
      if (i == 9) chk("R8 merged word written back", mem[8'h8E], 32'h12345678);
      if (i == 4) chk("R6 written-back data", mem[5], 32'hDEADBEEF);
    end

    // R1: low byte bits do not change the word
    access(1'b0, 10'h239, 32'h0);
    chk("R1 byte bits ignored", got, 32'h12345678);
    chk("R1 no traffic", rd_n + wr_n, 32'd0);

    // R10: a dirty line is forgotten across reset
    access(1'b1, 10'h300, 32'h00000055);
    chk("R8 write miss refill beats", rd_n, 32'd4);
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    access(1'b0, 10'h380, 32'h0);
    chk("R10 no write-back after reset", wr_n, 32'd0);
    chk("R10 line invalid after reset", rd_n, 32'd4);
    chk("R10 data from memory", got, 32'h100000E0);
    access(1'b0, 10'h300, 32'h0);
    chk("R10 dirty data dropped", got, 32'h100000C0);
    chk("R10 memory kept old word", mem[8'hC0], 32'h100000C0);

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk("watchdog expired", 32'd1, 32'd0);
    finish_run();
  end
endmodule